// File: doc/BRIEF.md
# In-Order Retirement Queue

This block tracks instructions between dispatch and retirement in a small circular queue of six slots. Dispatch claims a slot and records the architectural destination and the rename register that will hold the result. Execution units later report that a slot has finished and whether it raised an exception. The oldest entries leave the queue in program order, at most two per clock. Each departure drives a commit strobe that tells the register file to copy the rename register into the architected register.

Two events cut the queue short. A branch found to be mispredicted removes every entry younger than the branch. An entry that reaches the oldest position carrying an exception empties the whole queue. In both cases the rename registers of the removed entries are returned through a release mask, so their results never become architectural. A free-slot count is presented every cycle so that dispatch can stall on a full queue.

Top module: `retire_queue`

## Requirements
- R1: `free_count` equals six minus the number of occupied slots in every cycle and is 6 after reset. An allocation request made while `free_count` is 0 is dropped.
- R2: `alloc_slot` shows the slot that the next accepted allocation takes. Slots are handed out in the order 0, 1, 2, 3, 4, 5 and then 0 again.
- R3: `fin_valid` with `fin_slot` marks that occupied slot finished, and `fin_exc` is stored as its exception flag. A finish naming an unoccupied slot has no effect, so a later allocation into that slot does not appear finished.
- R4: The oldest entry commits in a cycle only if it has finished with no exception. In that same cycle `commit_valid[0]` is 1 and `commit_arch`/`commit_tag`/`commit_dst_en` bits [ARCH_W-1:0]/[TAG_W-1:0]/[0] carry its fields. The entry leaves the queue at the next clock edge.
- R5: `commit_valid[1]` is 1 only in a cycle where `commit_valid[0]` is 1 and the second-oldest entry has finished with no exception. A finished entry never commits while an older entry is unfinished.
- R6: When the oldest entry has finished with an exception, `exc_raise` is 1 for that cycle and nothing commits. `release_mask` bit t is 1 for every occupied entry that has a destination and holds rename tag t. After the next edge the queue is empty (`free_count` = 6).
- R7: `br_valid` with `br_mispredict` on an occupied `br_slot` sets the `release_mask` bits of all younger entries that have a destination, and removes those entries at the edge. Younger entries do not commit in that cycle. The branch and older entries stay, and `alloc_slot` then points to the slot after the branch. A request on an unoccupied slot has no effect.
- R8: An allocation request in a cycle that flushes (R6 or R7) is dropped.
- R9: In a cycle without a flush, the next `free_count` equals the current `free_count`, minus 1 if an allocation is accepted, plus the number of commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocation request from dispatch |
| alloc_arch | input | ARCH_W | Architected destination register index |
| alloc_tag | input | TAG_W | Rename register assigned to the result |
| alloc_dst_en | input | 1 | Instruction writes a destination |
| alloc_slot | output | IDX_W | Slot the next allocation takes |
| fin_valid | input | 1 | Finish report from an execution unit |
| fin_slot | input | IDX_W | Slot that finished |
| fin_exc | input | 1 | Finished instruction raised an exception |
| br_valid | input | 1 | Branch resolution report |
| br_slot | input | IDX_W | Slot of the resolved branch |
| br_mispredict | input | 1 | The branch was mispredicted |
| commit_valid | output | RETIRE_W | Commit strobe per retire lane, lane 0 oldest |
| commit_arch | output | RETIRE_W*ARCH_W | Architected index per lane |
| commit_tag | output | RETIRE_W*TAG_W | Rename register to copy per lane |
| commit_dst_en | output | RETIRE_W | Lane has a destination write |
| exc_raise | output | 1 | Precise exception at the oldest entry |
| release_mask | output | REN_NUM | Rename registers freed by a flush |
| free_count | output | CNT_W | Number of free slots |

## Verification
A wrong occupancy count first appears in `free_count` in the cycle after the faulty update. Drift does not correct itself, so every later full or empty check disagrees. A head or tail pointer that slips shows up at the next commit, when `commit_arch` names the wrong instruction or commits leave program order. The tail pointer is also visible at once on `alloc_slot`. A stale finished or exception flag left in a recycled slot shows up as a commit before any finish report for the new occupant, or as a spurious `exc_raise`. Both appear in the first cycle that slot is oldest. A wrong squash range appears in the same cycle as a wrong `release_mask` and one cycle later as a wrong `free_count` and `alloc_slot`.

// File: rtl/cq_pkg.sv
package cq_pkg;

   typedef struct packed {
      logic occ;
      logic done;
      logic exc;
      logic dst;
   } cq_flags_t;

   // advance a ring position by step (step never exceeds depth)
   function automatic int unsigned ring_add(int unsigned base, int unsigned step,
                                            int unsigned depth);
      int unsigned s;
      s = base + step;
      return (s >= depth) ? s - depth : s;
   endfunction

   // distance walked from position 'from' forward to position 'to'
   function automatic int unsigned ring_dist(int unsigned from, int unsigned to,
                                             int unsigned depth);
      return (to >= from) ? to - from : to + depth - from;
   endfunction

endpackage

// File: rtl/cq_store.sv
module cq_store #(
   parameter int DEPTH  = 6,
   parameter int ARCH_W = 5,
   parameter int TAG_W  = 3,
   parameter int IDX_W  = 3
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [IDX_W-1:0]                 wr_idx,
   input  logic [ARCH_W-1:0]                wr_arch,
   input  logic [TAG_W-1:0]                 wr_tag,
   input  logic                             wr_dst,
   input  logic                             fin_en,
   input  logic [IDX_W-1:0]                 fin_idx,
   input  logic                             fin_exc,
   input  logic [DEPTH-1:0]                 clr,
   output logic [DEPTH-1:0]                 occ,
   output logic [DEPTH-1:0]                 done,
   output logic [DEPTH-1:0]                 exc,
   output logic [DEPTH-1:0]                 dst,
   output logic [DEPTH-1:0][ARCH_W-1:0]     arch,
   output logic [DEPTH-1:0][TAG_W-1:0]      tag
);

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      cq_pkg::cq_flags_t   f_q;
      logic [ARCH_W-1:0]   arch_q;
      logic [TAG_W-1:0]    tag_q;
      logic                hit_wr;
      logic                hit_fin;

      assign hit_wr  = wr_en  && (wr_idx  == IDX_W'(i));
      assign hit_fin = fin_en && (fin_idx == IDX_W'(i)) && f_q.occ;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            f_q    <= '0;
            arch_q <= '0;
            tag_q  <= '0;
         end else if (clr[i]) begin
            f_q.occ  <= 1'b0;
            f_q.done <= 1'b0;
            f_q.exc  <= 1'b0;
         end else if (hit_wr) begin
            f_q.occ  <= 1'b1;
            f_q.done <= 1'b0;
            f_q.exc  <= 1'b0;
            f_q.dst  <= wr_dst;
            arch_q   <= wr_arch;
            tag_q    <= wr_tag;
         end else if (hit_fin) begin
            f_q.done <= 1'b1;
            f_q.exc  <= fin_exc;
         end
      end

      assign occ[i]  = f_q.occ;
      assign done[i] = f_q.done;
      assign exc[i]  = f_q.exc;
      assign dst[i]  = f_q.dst;
      assign arch[i] = arch_q;
      assign tag[i]  = tag_q;
   end

endmodule

// File: rtl/cq_retire_sel.sv
module cq_retire_sel #(
   parameter int DEPTH    = 6,
   parameter int RETIRE_W = 2,
   parameter int IDX_W    = 3,
   parameter int CNT_W    = 3
) (
   input  logic [IDX_W-1:0]                  head,
   input  logic [DEPTH-1:0]                  occ,
   input  logic [DEPTH-1:0]                  done,
   input  logic [DEPTH-1:0]                  exc,
   input  logic [DEPTH-1:0]                  squash,
   output logic [RETIRE_W-1:0]               go,
   output logic [RETIRE_W-1:0][IDX_W-1:0]    slot_idx,
   output logic                              exc_hit,
   output logic [CNT_W-1:0]                  n_ret
);

   logic [RETIRE_W-1:0] ok;

   for (genvar k = 0; k < RETIRE_W; k++) begin : g_lane
      assign slot_idx[k] = IDX_W'(cq_pkg::ring_add(int'(head), k, DEPTH));
      assign ok[k] = occ[slot_idx[k]] & done[slot_idx[k]] &
                     ~exc[slot_idx[k]] & ~squash[slot_idx[k]];
      if (k == 0) begin : g_first
         assign go[k] = ok[k];
      end else begin : g_chain
         assign go[k] = go[k-1] & ok[k];
      end
   end

   assign exc_hit = occ[head] & done[head] & exc[head];

   always_comb begin
      n_ret = '0;
      for (int k = 0; k < RETIRE_W; k++) begin
         if (go[k]) n_ret = n_ret + CNT_W'(1);
      end
   end

endmodule

// File: rtl/cq_flush_ctl.sv
module cq_flush_ctl #(
   parameter int DEPTH   = 6,
   parameter int IDX_W   = 3,
   parameter int TAG_W   = 3,
   parameter int REN_NUM = 6,
   parameter int CNT_W   = 3
) (
   input  logic [IDX_W-1:0]              head,
   input  logic [DEPTH-1:0]              occ,
   input  logic [DEPTH-1:0]              dst,
   input  logic [DEPTH-1:0][TAG_W-1:0]   tag,
   input  logic                          exc_hit,
   input  logic                          br_valid,
   input  logic                          br_mispredict,
   input  logic [IDX_W-1:0]              br_idx,
   output logic [DEPTH-1:0]              squash,
   output logic                          br_flush,
   output logic                          flush_any,
   output logic [IDX_W-1:0]              new_tail,
   output logic [CNT_W-1:0]              keep_cnt,
   output logic [REN_NUM-1:0]            release_mask
);

   logic        br_in_range;
   int unsigned br_age;

   assign br_in_range = (br_idx < IDX_W'(DEPTH));
   assign br_flush    = br_valid & br_mispredict & br_in_range & occ[br_idx] & ~exc_hit;
   assign flush_any   = br_flush | exc_hit;
   assign br_age      = cq_pkg::ring_dist(int'(head), int'(br_idx), DEPTH);

   for (genvar i = 0; i < DEPTH; i++) begin : g_sq
      int unsigned age;
      assign age       = cq_pkg::ring_dist(int'(head), i, DEPTH);
      assign squash[i] = occ[i] & (exc_hit | (br_flush & (age > br_age)));
   end

   always_comb begin
      if (exc_hit) begin
         new_tail = head;
         keep_cnt = '0;
      end else begin
         new_tail = IDX_W'(cq_pkg::ring_add(int'(br_idx), 1, DEPTH));
         keep_cnt = CNT_W'(br_age + 1);
      end
   end

   always_comb begin
      release_mask = '0;
      for (int j = 0; j < REN_NUM; j++) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (squash[i] && dst[i] && (tag[i] == TAG_W'(j))) release_mask[j] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/retire_queue.sv
module retire_queue #(
   parameter int DEPTH    = 6,
   parameter int RETIRE_W = 2,
   parameter int ARCH_W   = 5,
   parameter int REN_NUM  = 6,
   localparam int IDX_W   = $clog2(DEPTH),
   localparam int TAG_W   = $clog2(REN_NUM),
   localparam int CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         alloc_valid,
   input  logic [ARCH_W-1:0]            alloc_arch,
   input  logic [TAG_W-1:0]             alloc_tag,
   input  logic                         alloc_dst_en,
   output logic [IDX_W-1:0]             alloc_slot,
   input  logic                         fin_valid,
   input  logic [IDX_W-1:0]             fin_slot,
   input  logic                         fin_exc,
   input  logic                         br_valid,
   input  logic [IDX_W-1:0]             br_slot,
   input  logic                         br_mispredict,
   output logic [RETIRE_W-1:0]          commit_valid,
   output logic [RETIRE_W*ARCH_W-1:0]   commit_arch,
   output logic [RETIRE_W*TAG_W-1:0]    commit_tag,
   output logic [RETIRE_W-1:0]          commit_dst_en,
   output logic                         exc_raise,
   output logic [REN_NUM-1:0]           release_mask,
   output logic [CNT_W-1:0]             free_count
);

   // elaboration-time parameter checks
   if (DEPTH < 2) begin : g_bad_depth
      $error("retire_queue: DEPTH must be at least 2");
   end
   if (RETIRE_W < 1 || RETIRE_W > DEPTH) begin : g_bad_width
      $error("retire_queue: RETIRE_W must lie in 1..DEPTH");
   end
   if (REN_NUM < 2) begin : g_bad_ren
      $error("retire_queue: REN_NUM must be at least 2");
   end
   if (ARCH_W < 1) begin : g_bad_arch
      $error("retire_queue: ARCH_W must be positive");
   end

   logic [IDX_W-1:0]                 head_q, tail_q;
   logic [CNT_W-1:0]                 count_q;
   logic [DEPTH-1:0]                 occ, done, exc, dst, squash, clr;
   logic [DEPTH-1:0][ARCH_W-1:0]     arch;
   logic [DEPTH-1:0][TAG_W-1:0]      tag;
   logic [RETIRE_W-1:0]              go;
   logic [RETIRE_W-1:0][IDX_W-1:0]   slot_idx;
   logic                             exc_hit, br_flush, flush_any, alloc_go;
   logic [CNT_W-1:0]                 n_ret, keep_cnt;
   logic [IDX_W-1:0]                 new_tail;

   assign alloc_go = alloc_valid & (count_q != CNT_W'(DEPTH)) & ~flush_any;

   cq_store #(
      .DEPTH(DEPTH), .ARCH_W(ARCH_W), .TAG_W(TAG_W), .IDX_W(IDX_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(alloc_go), .wr_idx(tail_q), .wr_arch(alloc_arch),
      .wr_tag(alloc_tag), .wr_dst(alloc_dst_en),
      .fin_en(fin_valid), .fin_idx(fin_slot), .fin_exc(fin_exc),
      .clr(clr),
      .occ(occ), .done(done), .exc(exc), .dst(dst), .arch(arch), .tag(tag)
   );

   cq_retire_sel #(
      .DEPTH(DEPTH), .RETIRE_W(RETIRE_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
   ) u_sel (
      .head(head_q), .occ(occ), .done(done), .exc(exc), .squash(squash),
      .go(go), .slot_idx(slot_idx), .exc_hit(exc_hit), .n_ret(n_ret)
   );

   cq_flush_ctl #(
      .DEPTH(DEPTH), .IDX_W(IDX_W), .TAG_W(TAG_W), .REN_NUM(REN_NUM), .CNT_W(CNT_W)
   ) u_flush (
      .head(head_q), .occ(occ), .dst(dst), .tag(tag),
      .exc_hit(exc_hit), .br_valid(br_valid), .br_mispredict(br_mispredict),
      .br_idx(br_slot),
      .squash(squash), .br_flush(br_flush), .flush_any(flush_any),
      .new_tail(new_tail), .keep_cnt(keep_cnt), .release_mask(release_mask)
   );

   // slots leaving the queue this cycle: retired lanes plus squashed entries
   always_comb begin
      clr = squash;
      for (int k = 0; k < RETIRE_W; k++) begin
         if (go[k]) clr[slot_idx[k]] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
      end else begin
         head_q <= IDX_W'(cq_pkg::ring_add(int'(head_q), int'(n_ret), DEPTH));
         if (flush_any) begin
            tail_q  <= new_tail;
            count_q <= keep_cnt - n_ret;
         end else begin
            tail_q  <= IDX_W'(cq_pkg::ring_add(int'(tail_q), int'(alloc_go), DEPTH));
            count_q <= count_q + CNT_W'(alloc_go) - n_ret;
         end
      end
   end

   for (genvar k = 0; k < RETIRE_W; k++) begin : g_out
      assign commit_valid[k]                   = go[k];
      assign commit_arch[k*ARCH_W +: ARCH_W]   = arch[slot_idx[k]];
      assign commit_tag[k*TAG_W +: TAG_W]      = tag[slot_idx[k]];
      assign commit_dst_en[k]                  = dst[slot_idx[k]];
   end

   assign exc_raise  = exc_hit;
   assign alloc_slot = tail_q;
   assign free_count = CNT_W'(DEPTH) - count_q;

endmodule

// File: rtl/cq_checker.sv
module cq_checker #(
   parameter int DEPTH    = 6,
   parameter int RETIRE_W = 2,
   parameter int REN_NUM  = 6,
   parameter int CNT_W    = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  alloc_valid,
   input logic                  exc_raise,
   input logic                  flush_any,
   input logic [RETIRE_W-1:0]   commit_valid,
   input logic [REN_NUM-1:0]    release_mask,
   input logic [CNT_W-1:0]      free_count
);

   localparam int FW = CNT_W + 1;

   logic          acc;
   logic [FW-1:0] nxt_free;

   always_comb begin
      acc      = alloc_valid && (free_count != '0) && !flush_any;
      nxt_free = {1'b0, free_count} - FW'(acc) + FW'($countones(commit_valid));
   end

   p_free_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      free_count <= CNT_W'(DEPTH));

   p_full_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (free_count == '0 && !flush_any && commit_valid == '0) |=> free_count == '0);

   for (genvar k = 1; k < RETIRE_W; k++) begin : g_order
      p_lane_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
         commit_valid[k] |-> commit_valid[k-1]);
   end

   p_exc_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      exc_raise |-> commit_valid == '0);

   p_exc_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      exc_raise |=> free_count == CNT_W'(DEPTH));

   p_release_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (release_mask != '0) |-> flush_any);

   p_count_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !flush_any |=> {1'b0, free_count} == $past(nxt_free));

endmodule

bind retire_queue cq_checker #(
   .DEPTH(DEPTH), .RETIRE_W(RETIRE_W), .REN_NUM(REN_NUM), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .exc_raise(exc_raise),
   .flush_any(flush_any), .commit_valid(commit_valid),
   .release_mask(release_mask), .free_count(free_count)
);

// File: tb/retire_queue_test.sv
module retire_queue_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       alloc_valid = 1'b0;
   logic [4:0] alloc_arch = '0;
   logic [2:0] alloc_tag = '0;
   logic       alloc_dst_en = 1'b0;
   logic [2:0] alloc_slot;
   logic       fin_valid = 1'b0;
   logic [2:0] fin_slot = '0;
   logic       fin_exc = 1'b0;
   logic       br_valid = 1'b0;
   logic [2:0] br_slot = '0;
   logic       br_mispredict = 1'b0;
   logic [1:0] commit_valid;
   logic [9:0] commit_arch;
   logic [5:0] commit_tag;
   logic [1:0] commit_dst_en;
   logic       exc_raise;
   logic [5:0] release_mask;
   logic [2:0] free_count;

   int n_total = 0;
   int n_pass  = 0;

   always #5 clk = ~clk;

   retire_queue uut (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_arch(alloc_arch), .alloc_tag(alloc_tag),
      .alloc_dst_en(alloc_dst_en), .alloc_slot(alloc_slot),
      .fin_valid(fin_valid), .fin_slot(fin_slot), .fin_exc(fin_exc),
      .br_valid(br_valid), .br_slot(br_slot), .br_mispredict(br_mispredict),
      .commit_valid(commit_valid), .commit_arch(commit_arch), .commit_tag(commit_tag),
      .commit_dst_en(commit_dst_en), .exc_raise(exc_raise),
      .release_mask(release_mask), .free_count(free_count)
   );

   typedef struct packed {
      logic       av;
      logic [4:0] arch;
      logic [2:0] tag;
      logic       fv;
      logic [2:0] fidx;
      logic       fexc;
      logic [2:0] efree;
      logic [1:0] ecv;
      logic [4:0] earch0;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 5'd1, 3'd1, 1'b0, 3'd0, 1'b0, 3'd6, 2'b00, 5'd0},
      '{1'b1, 5'd2, 3'd2, 1'b1, 3'd0, 1'b0, 3'd5, 2'b00, 5'd0},
      '{1'b1, 5'd3, 3'd3, 1'b0, 3'd0, 1'b0, 3'd4, 2'b01, 5'd1},
      '{1'b0, 5'd0, 3'd0, 1'b1, 3'd2, 1'b0, 3'd4, 2'b00, 5'd0},
      '{1'b0, 5'd0, 3'd0, 1'b1, 3'd1, 1'b0, 3'd4, 2'b00, 5'd0},
      '{1'b0, 5'd0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd4, 2'b11, 5'd2},
      '{1'b1, 5'd4, 3'd4, 1'b0, 3'd0, 1'b0, 3'd6, 2'b00, 5'd0},
      '{1'b1, 5'd5, 3'd5, 1'b1, 3'd3, 1'b0, 3'd5, 2'b00, 5'd0},
      '{1'b1, 5'd6, 3'd0, 1'b1, 3'd4, 1'b0, 3'd4, 2'b01, 5'd4},
      '{1'b1, 5'd7, 3'd1, 1'b1, 3'd5, 1'b0, 3'd4, 2'b01, 5'd5},
      '{1'b0, 5'd0, 3'd0, 1'b1, 3'd0, 1'b0, 3'd4, 2'b01, 5'd6},
      '{1'b0, 5'd0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd5, 2'b01, 5'd7},
      '{1'b0, 5'd0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd6, 2'b00, 5'd0}
   };

   task automatic chk(input string req, input int act, input int exp);
      n_total++;
      if (act == exp) n_pass++;
      else $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
   endtask

   // drive one cycle of inputs after the falling edge; outputs settle 1 ns later
   task automatic drive(input bit av, input int arch, input int tag, input bit dsten,
                        input bit fv, input int fidx, input bit fexc,
                        input bit bv, input int bidx, input bit bmis);
      @(negedge clk);
      alloc_valid   = av;
      alloc_arch    = 5'(arch);
      alloc_tag     = 3'(tag);
      alloc_dst_en  = dsten;
      fin_valid     = fv;
      fin_slot      = 3'(fidx);
      fin_exc       = fexc;
      br_valid      = bv;
      br_slot       = 3'(bidx);
      br_mispredict = bmis;
      #1;
   endtask

   task automatic idle();
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      alloc_valid = 1'b0; fin_valid = 1'b0; br_valid = 1'b0; br_mispredict = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(200000 * 10);
      n_total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
   end

   initial begin
      do_reset();
      #1;
      // reset state
      chk("R1 reset free", int'(free_count), 6);
      chk("R4 reset commit", int'(commit_valid), 0);
      chk("R6 reset exc", int'(exc_raise), 0);
      chk("R2 reset slot", int'(alloc_slot), 0);

      // table walk: in-order retirement, dual commit, wrap, alloc+retire overlap
      for (int v = 0; v < NV; v++) begin
         drive(VEC[v].av, int'(VEC[v].arch), int'(VEC[v].tag), 1'b1,
               VEC[v].fv, int'(VEC[v].fidx), VEC[v].fexc, 0, 0, 0);
         chk("R1 R9 table free", int'(free_count), int'(VEC[v].efree));
         chk("R4 R5 table commit", int'(commit_valid), int'(VEC[v].ecv));
         if (VEC[v].ecv[0])
            chk("R4 table arch", int'(commit_arch[4:0]), int'(VEC[v].earch0));
      end

      // full queue, allocation order and drop when full
      do_reset();
      for (int i = 0; i < 6; i++) begin
         drive(1, 10 + i, i, 1, 0, 0, 0, 0, 0, 0);
         chk("R2 slot order", int'(alloc_slot), i);
      end
      drive(1, 31, 0, 1, 0, 0, 0, 0, 0, 0);
      chk("R1 full free", int'(free_count), 0);
      begin
         int n_seen;
         n_seen = 0;
         for (int c = 0; c < 10; c++) begin
            if (c < 6) drive(0, 0, 0, 0, 1, c, 0, 0, 0, 0);
            else idle();
            if (c == 0) chk("R1 drop when full", int'(free_count), 0);
            if (commit_valid[0]) begin
               chk("R5 order lane0", int'(commit_arch[4:0]), 10 + n_seen);
               n_seen++;
            end
            if (commit_valid[1]) begin
               chk("R5 order lane1", int'(commit_arch[9:5]), 10 + n_seen);
               n_seen++;
            end
         end
         chk("R1 commits of full queue", n_seen, 6);
      end
      chk("R1 empty after drain", int'(free_count), 6);
      chk("R2 slot wrap", int'(alloc_slot), 0);

      // precise exception at head
      do_reset();
      drive(1, 1, 1, 1, 0, 0, 0, 0, 0, 0);
      drive(1, 2, 2, 1, 0, 0, 0, 0, 0, 0);
      drive(1, 3, 3, 1, 0, 0, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 1, 1, 1, 0, 0, 0);
      chk("R5 exc blocks lane1", int'(commit_valid), 1);
      chk("R3 exc not yet raised", int'(exc_raise), 0);
      drive(1, 9, 5, 1, 1, 2, 0, 0, 0, 0);
      chk("R6 exc raise", int'(exc_raise), 1);
      chk("R6 no commit", int'(commit_valid), 0);
      chk("R6 release", int'(release_mask), 6'b001100);
      idle();
      chk("R6 R8 emptied", int'(free_count), 6);
      chk("R6 exc cleared", int'(exc_raise), 0);

      // mispredicted branch in slot 1
      do_reset();
      drive(1, 1, 1, 1, 0, 0, 0, 0, 0, 0);
      drive(1, 2, 2, 0, 0, 0, 0, 0, 0, 0);
      drive(1, 3, 3, 1, 0, 0, 0, 0, 0, 0);
      drive(1, 4, 4, 1, 0, 0, 0, 0, 0, 0);
      drive(1, 9, 5, 1, 0, 0, 0, 1, 1, 1);
      chk("R7 release younger", int'(release_mask), 6'b011000);
      chk("R7 no commit", int'(commit_valid), 0);
      drive(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
      chk("R7 R8 free after squash", int'(free_count), 4);
      chk("R7 tail after branch", int'(alloc_slot), 2);
      chk("R7 release quiet", int'(release_mask), 0);
      drive(0, 0, 0, 0, 1, 1, 0, 0, 0, 0);
      chk("R4 kept head commits", int'(commit_valid), 1);
      chk("R4 kept head arch", int'(commit_arch[4:0]), 1);
      chk("R4 head dst", int'(commit_dst_en[0]), 1);
      idle();
      chk("R4 branch commits", int'(commit_valid), 1);
      chk("R4 branch arch", int'(commit_arch[4:0]), 2);
      chk("R4 branch no dst", int'(commit_dst_en[0]), 0);
      idle();
      chk("R8 dropped alloc absent", int'(commit_valid), 0);
      chk("R7 empty", int'(free_count), 6);

      // mispredict on unoccupied slot ignored
      drive(0, 0, 0, 0, 0, 0, 0, 1, 4, 1);
      chk("R7 ignore empty branch", int'(release_mask), 0);
      idle();
      chk("R7 free unchanged", int'(free_count), 6);

      // finish to an unoccupied slot is ignored
      do_reset();
      drive(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
      drive(1, 5, 1, 1, 0, 0, 0, 0, 0, 0);
      idle();
      chk("R3 stale finish ignored", int'(commit_valid), 0);
      chk("R3 free", int'(free_count), 5);

      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
   end

endmodule